// File: doc/BRIEF.md
# PHY Update Request Responder

This block answers update requests that a PHY raises toward a memory controller across a DFI-style interface. A PHY may ask for an update of four kinds, identified by a 2-bit kind code. For each kind, software chooses one of two reactions. The block can put the memory devices into self-refresh and then hold the DFI quiet. Or it can hold the DFI quiet without touching the memory state. The four choices live in one 32-bit policy register.

Software reaches the policy register through a simple write strobe and an always-valid read bus. A write is honoured only while the controller reports its configuration state or its low-power state. Entry to and exit from self-refresh are handshakes with an external sequencer; the block only raises the requests and waits for the completion signals.

A request follows a level req/ack handshake. The block blocks new commands and, when the policy asks for it, finishes self-refresh entry. It then raises ack and keeps it high until the PHY drops req. After that it undoes the preparation and releases the command block.

Top module: `phyupd_responder`

## Requirements
- R1: After reset, the read bus returns zero and ack, command hold, self-refresh entry request, self-refresh exit request and the error flag are all low.
- R2: A register write takes effect only when ctrl_state is 2'b01 (configuration) or 2'b10 (low power). With ctrl_state 2'b00 or 2'b11 the write is ignored and the read bus keeps its old value.
- R3: The read bus returns the policy bits in [7:0]. Bits [31:8] always read as zero, whatever was written to them.
- R4: The policy for update kind n is held in register bits [2n+1:2n].
- R5: Policy code 2'b00 means self-refresh entry before the stall. In the cycle after the request is taken, hold and sr_enter_req rise. sr_enter_req stays high until sr_enter_done is sampled high. ack is low until then and rises in the cycle after sr_enter_done.
- R6: Policy code 2'b01 means stall only. Hold and ack rise in the cycle after the request is taken, and neither self-refresh request is raised.
- R7: Policy codes 2'b10 and 2'b11 are reserved. A request that selects one is handled as stall only, and the error flag is set in the cycle after the request is taken.
- R8: ack falls in the cycle after req is sampled low. If self-refresh was entered, sr_exit_req is raised with hold kept high, and hold falls in the cycle after sr_exit_done. Otherwise hold falls together with ack.
- R9: The update kind and its policy are captured when the request is taken. Changes to phy_upd_type or to the register during the handshake do not alter how that handshake finishes.
- R10: Once set, the error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_state | input | 2 | Controller state: 00 active, 01 configuration, 10 low power, 11 other |
| reg_wr_en | input | 1 | Policy register write strobe |
| reg_wdata | input | 32 | Policy register write data |
| reg_rdata | output | 32 | Policy register read data |
| phy_upd_req | input | 1 | Update request from the PHY (level) |
| phy_upd_type | input | 2 | Update kind from the PHY |
| phy_upd_ack | output | 1 | Update acknowledge to the PHY |
| cmd_hold | output | 1 | Blocks new commands and holds the DFI stalled |
| sr_enter_req | output | 1 | Request to the sequencer for self-refresh entry |
| sr_enter_done | input | 1 | Self-refresh entry complete |
| sr_exit_req | output | 1 | Request to the sequencer for self-refresh exit |
| sr_exit_done | input | 1 | Self-refresh exit complete |
| policy_err | output | 1 | Sticky flag: a request selected a reserved policy |

## Verification
A wrong handshake state shows at the ports within one cycle of the event that should have moved it. If ack rises while sr_enter_req is still high, self-refresh was skipped. If hold drops with no sr_exit_req, the devices were left in self-refresh. A wrongly captured kind or policy shows when the exit path differs from the path taken on entry. A gating fault in the register shows at the next read after a write in a forbidden state. A policy field decoded in the wrong place shows on the first request of the affected kind as the wrong path or a wrong error flag.

// File: rtl/phyupd_pkg.sv
package phyupd_pkg;

  typedef enum logic [1:0] {
    CS_ACTIVE = 2'b00,
    CS_CONFIG = 2'b01,
    CS_LOWPWR = 2'b10,
    CS_OTHER  = 2'b11
  } ctrl_state_e;

  typedef enum logic [1:0] {
    POL_SR_THEN_STALL = 2'b00,
    POL_STALL_ONLY    = 2'b01,
    POL_RSV_A         = 2'b10,
    POL_RSV_B         = 2'b11
  } upd_policy_e;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'b00,
    HS_SR_IN  = 2'b01,
    HS_ACKED  = 2'b10,
    HS_SR_OUT = 2'b11
  } hs_state_e;

  function automatic logic write_permitted(input logic [1:0] cs);
    return (cs == CS_CONFIG) || (cs == CS_LOWPWR);
  endfunction

  function automatic logic policy_needs_sr(input logic [1:0] pol);
    return pol == POL_SR_THEN_STALL;
  endfunction

  function automatic logic policy_reserved(input logic [1:0] pol);
    return (pol == POL_RSV_A) || (pol == POL_RSV_B);
  endfunction

endpackage

// File: rtl/phyupd_policy_regs.sv
module phyupd_policy_regs
  import phyupd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctrl_state,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TYPE_W-1:0] lookup_type,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        lookup_pol,
  output logic              wr_taken
);
  localparam int NUM_TYPES = 1 << TYPE_W;
  localparam int FIELD_W   = 2;
  localparam int POL_BITS  = NUM_TYPES * FIELD_W;
  localparam int PAD_W     = DATA_W - POL_BITS;

  logic [POL_BITS-1:0] pol_q;
  logic [FIELD_W-1:0]  field [NUM_TYPES];

  assign wr_taken = wr_en && write_permitted(ctrl_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
    end else if (wr_taken) begin
      pol_q <= wdata[POL_BITS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_field
    assign field[g] = pol_q[g*FIELD_W +: FIELD_W];
  end

  assign lookup_pol = field[lookup_type];
  assign rdata      = {{PAD_W{1'b0}}, pol_q};

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:POL_BITS];

endmodule

// File: rtl/phyupd_hs_fsm.sv
module phyupd_hs_fsm
  import phyupd_pkg::*;
#(
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_req,
  input  logic [TYPE_W-1:0] upd_type,
  input  logic [1:0]        pol,
  input  logic              sr_in_done,
  input  logic              sr_out_done,
  output logic              ack,
  output logic              hold,
  output logic              sr_in_req,
  output logic              sr_out_req,
  output logic              accept,
  output logic              rsv_hit,
  output logic [TYPE_W-1:0] type_q,
  output logic              sr_used_q
);
  hs_state_e state_q, state_d;

  assign accept  = (state_q == HS_IDLE) && upd_req;
  assign rsv_hit = accept && policy_reserved(pol);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:   if (upd_req) state_d = policy_needs_sr(pol) ? HS_SR_IN : HS_ACKED;
      HS_SR_IN:  if (sr_in_done) state_d = HS_ACKED;
      HS_ACKED:  if (!upd_req) state_d = sr_used_q ? HS_SR_OUT : HS_IDLE;
      HS_SR_OUT: if (sr_out_done) state_d = HS_IDLE;
      default:   state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      type_q    <= '0;
      sr_used_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        type_q    <= upd_type;
        sr_used_q <= policy_needs_sr(pol);
      end
    end
  end

  assign ack        = (state_q == HS_ACKED);
  assign hold       = (state_q != HS_IDLE);
  assign sr_in_req  = (state_q == HS_SR_IN);
  assign sr_out_req = (state_q == HS_SR_OUT);

endmodule

// File: rtl/phyupd_err_flag.sv
module phyupd_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/phyupd_responder.sv
module phyupd_responder
  import phyupd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctrl_state,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              phy_upd_req,
  input  logic [TYPE_W-1:0] phy_upd_type,
  output logic              phy_upd_ack,
  output logic              cmd_hold,
  output logic              sr_enter_req,
  input  logic              sr_enter_done,
  output logic              sr_exit_req,
  input  logic              sr_exit_done,
  output logic              policy_err
);
  logic [1:0]        sel_pol;
  logic              wr_taken;
  logic              upd_accept;
  logic              rsv_hit;
  logic [TYPE_W-1:0] upd_type_q;
  logic              sr_used_q;

  phyupd_policy_regs #(.DATA_W(DATA_W), .TYPE_W(TYPE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_state(ctrl_state),
    .wr_en(reg_wr_en), .wdata(reg_wdata), .lookup_type(phy_upd_type),
    .rdata(reg_rdata), .lookup_pol(sel_pol), .wr_taken(wr_taken)
  );

  phyupd_hs_fsm #(.TYPE_W(TYPE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .upd_req(phy_upd_req), .upd_type(phy_upd_type),
    .pol(sel_pol), .sr_in_done(sr_enter_done), .sr_out_done(sr_exit_done),
    .ack(phy_upd_ack), .hold(cmd_hold), .sr_in_req(sr_enter_req),
    .sr_out_req(sr_exit_req), .accept(upd_accept), .rsv_hit(rsv_hit),
    .type_q(upd_type_q), .sr_used_q(sr_used_q)
  );

  phyupd_err_flag u_err (
    .clk(clk), .rst_n(rst_n), .set(rsv_hit), .flag(policy_err)
  );

endmodule

// File: rtl/phyupd_responder_chk.sv
module phyupd_responder_chk #(
  parameter int DATA_W = 32,
  parameter int TYPE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctrl_state,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              phy_upd_req,
  input logic              phy_upd_ack,
  input logic              cmd_hold,
  input logic              sr_enter_req,
  input logic              sr_exit_req,
  input logic              policy_err,
  input logic              upd_accept,
  input logic              rsv_hit,
  input logic              sr_used_q,
  input logic [TYPE_W-1:0] upd_type_q
);
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (ctrl_state == 2'b00 || ctrl_state == 2'b11)) |=> $stable(reg_rdata)); // R2
  AST_NO_ACK_IN_SR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter_req |-> !phy_upd_ack); // R5
  AST_ACK_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phy_upd_ack |-> cmd_hold); // R6
  AST_RSV_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_hit |=> policy_err); // R7
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_upd_ack && !phy_upd_req) |=> !phy_upd_ack); // R8
  AST_SR_EXIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_req |-> (cmd_hold && sr_used_q)); // R8
  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hold && !upd_accept) |=> (!cmd_hold || $stable(upd_type_q))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    policy_err |=> policy_err); // R10
endmodule

bind phyupd_responder phyupd_responder_chk #(.DATA_W(DATA_W), .TYPE_W(TYPE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_state(ctrl_state), .reg_wr_en(reg_wr_en),
  .reg_rdata(reg_rdata), .phy_upd_req(phy_upd_req), .phy_upd_ack(phy_upd_ack),
  .cmd_hold(cmd_hold), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
  .policy_err(policy_err), .upd_accept(upd_accept), .rsv_hit(rsv_hit),
  .sr_used_q(sr_used_q), .upd_type_q(upd_type_q)
);

// File: tb/phyupd_responder_tb_top.sv
module phyupd_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctrl_state = 2'b00;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        phy_upd_req = 1'b0;
  logic [1:0]  phy_upd_type = 2'b00;
  logic        phy_upd_ack, cmd_hold, sr_enter_req, sr_exit_req, policy_err;
  logic        sr_enter_done = 1'b0;
  logic        sr_exit_done = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phyupd_responder dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_state(ctrl_state), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phy_upd_req(phy_upd_req),
    .phy_upd_type(phy_upd_type), .phy_upd_ack(phy_upd_ack), .cmd_hold(cmd_hold),
    .sr_enter_req(sr_enter_req), .sr_enter_done(sr_enter_done),
    .sr_exit_req(sr_exit_req), .sr_exit_done(sr_exit_done), .policy_err(policy_err)
  );

  // {policy byte, type, expect self-refresh, expect error}
  localparam logic [11:0] VEC [10] = '{
    {8'hE4, 2'd0, 1'b1, 1'b0}, {8'hE4, 2'd1, 1'b0, 1'b0},
    {8'hE4, 2'd2, 1'b0, 1'b1}, {8'hE4, 2'd3, 1'b0, 1'b1},
    {8'h1B, 2'd0, 1'b0, 1'b1}, {8'h1B, 2'd1, 1'b0, 1'b1},
    {8'h1B, 2'd2, 1'b0, 1'b0}, {8'h1B, 2'd3, 1'b1, 1'b0},
    {8'h55, 2'd3, 1'b0, 1'b0}, {8'h15, 2'd3, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic reg_write(input logic [1:0] cs, input logic [31:0] d);
    @(negedge clk); ctrl_state = cs; reg_wr_en = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0; ctrl_state = 2'b00;
  endtask

  // Full handshake; checks entry path, ack timing, exit path.
  task automatic handshake(input logic [1:0] t, input bit exp_sr, input bit exp_err,
                           input bit disturb);
    @(negedge clk); phy_upd_req = 1'b1; phy_upd_type = t;
    @(negedge clk);
    chk("R5/R6 hold after accept", {31'd0, cmd_hold}, 32'd1);
    chk("R5/R6 sr_enter_req path", {31'd0, sr_enter_req}, {31'd0, exp_sr});
    chk("R5/R6 ack timing", {31'd0, phy_upd_ack}, {31'd0, !exp_sr});
    chk("R7 error flag", {31'd0, policy_err}, {31'd0, exp_err});
    if (disturb) begin
      phy_upd_type = ~t;
      reg_write(2'b01, 32'h0000_0055);
    end
    if (exp_sr) begin
      @(negedge clk);
      chk("R5 ack waits for entry done", {31'd0, phy_upd_ack}, 32'd0);
      chk("R5 entry request held", {31'd0, sr_enter_req}, 32'd1);
      sr_enter_done = 1'b1;
      @(negedge clk); sr_enter_done = 1'b0;
      chk("R5 ack after entry done", {31'd0, phy_upd_ack}, 32'd1);
      chk("R5 entry request dropped", {31'd0, sr_enter_req}, 32'd0);
    end
    @(negedge clk); phy_upd_req = 1'b0;
    @(negedge clk);
    chk("R8 ack falls", {31'd0, phy_upd_ack}, 32'd0);
    chk("R8/R9 exit request path", {31'd0, sr_exit_req}, {31'd0, exp_sr});
    chk("R8 hold while exiting", {31'd0, cmd_hold}, {31'd0, exp_sr});
    if (exp_sr) begin
      @(negedge clk);
      chk("R8 hold kept until exit done", {31'd0, cmd_hold}, 32'd1);
      sr_exit_done = 1'b1;
      @(negedge clk); sr_exit_done = 1'b0;
      chk("R8 hold released", {31'd0, cmd_hold}, 32'd0);
      chk("R8 exit request dropped", {31'd0, sr_exit_req}, 32'd0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    @(negedge clk);
    chk("R1 rdata", reg_rdata, 32'd0);
    chk("R1 outputs", {27'd0, phy_upd_ack, cmd_hold, sr_enter_req, sr_exit_req, policy_err}, 32'd0);

    // Vector table: program, then run one request (R4, R5, R6, R7, R8)
    for (int i = 0; i < 10; i++) begin
      do_reset();
      reg_write(2'b01, {24'd0, VEC[i][11:4]});
      handshake(VEC[i][3:2], VEC[i][1], VEC[i][0], 1'b0);
    end

    // R2 write gating, R3 upper bits read zero
    do_reset();
    reg_write(2'b10, 32'hFFFF_FF5A);
    @(negedge clk);
    chk("R3 upper bits zero, low-power write taken", reg_rdata, 32'h0000_005A);
    reg_write(2'b00, 32'h0000_0011);
    @(negedge clk);
    chk("R2 write ignored in active", reg_rdata, 32'h0000_005A);
    reg_write(2'b11, 32'h0000_0022);
    @(negedge clk);
    chk("R2 write ignored in other", reg_rdata, 32'h0000_005A);
    reg_write(2'b01, 32'h0000_00C3);
    @(negedge clk);
    chk("R2 write taken in configuration", reg_rdata, 32'h0000_00C3);

    // R9 capture: type 1 with policy 00 (byte 0xF3), disturbed mid-handshake
    do_reset();
    reg_write(2'b01, 32'h0000_00F3);
    handshake(2'd1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 register took the mid-handshake write", reg_rdata, 32'h0000_0055);

    // R10 sticky error
    do_reset();
    reg_write(2'b01, 32'h0000_0002);
    handshake(2'd0, 1'b0, 1'b1, 1'b0);
    reg_write(2'b01, 32'h0000_0001);
    handshake(2'd0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10 error stays set", {31'd0, policy_err}, 32'd1);
    do_reset();
    @(negedge clk);
    chk("R10/R1 error cleared by reset", {31'd0, policy_err}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule